// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block is the operating-mode state machine that sits beside a CAN protocol engine. It decides when the engine may run and reports the current mode to software through two acknowledge flags and a mode code. The modes are sleep, freeze (configuration), normal and bus-off. Register bits supply the sleep and freeze requests and two automatic-exit policies. The protocol engine supplies a busy flag, a bus-off flag, a start-of-frame detect, a sample-point strobe and the sampled RX level.

Each exit from sleep, freeze or bus-off is qualified by bus idle. Bus idle means eleven consecutive recessive samples, counted only at sample-point strobes. Entry into freeze or sleep from normal waits for the frame in progress to complete. When automatic wake is enabled, seeing bus activity while asleep starts the wake sequence and pulses a clear strobe for the sleep request bit. Bus-off recovery is either automatic or must go through one freeze entry and exit. While the engine is held, the transmit line is forced recessive.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the mode is sleep (`mode_o` = 2'b00, encodings: 00 sleep, 01 freeze, 10 normal, 11 bus-off), `sleep_ack_o` is 1, `freeze_ack_o` is 0, `engine_run_o` is 0 and `tx_o` is 1.
- R2: With automatic wake disabled, `sof_det_i` has no effect during sleep. After software clears `sleep_req_i`, the mode becomes normal only after a bus-idle detection, and `sleep_ack_o` stays 1 until then.
- R3: With automatic wake enabled, `sof_det_i` during sleep gives a one-cycle `sleep_clr_o` pulse in the next cycle and starts the wake sequence. The mode becomes normal after the next bus-idle detection.
- R4: In normal mode a freeze request is honoured only in a cycle with `busy_i` low. Then `freeze_ack_o` rises and `sleep_ack_o` is 0.
- R5: After the freeze request is released, the mode stays freeze until eleven consecutive recessive samples have been seen. A dominant sample restarts the count.
- R6: `idle_pulse_o` is a one-cycle pulse, raised in the cycle after a sample strobe with `rx_i` high that completes eleven consecutive recessive samples. Samples are counted only while a bus-idle exit is pending.
- R7: When the sleep and freeze requests are both set, freeze is entered. `sleep_ack_o` and `freeze_ack_o` are never 1 together.
- R8: `bus_off_i` in normal mode moves the mode to bus-off. With automatic bus-off exit enabled, the next bus-idle detection returns the mode to normal with a one-cycle `bo_recover_o` pulse.
- R9: With automatic bus-off exit disabled, bus-off persists through any amount of idle bus. A freeze entry and release followed by bus-idle returns the mode to normal with a `bo_recover_o` pulse.
- R10: `engine_run_o` is 1 only in normal mode. In every other mode `tx_o` is 1; in normal mode `tx_o` follows `tx_eng_i`.
- R11: A sleep request in normal mode is honoured only in a cycle with `busy_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Sleep request register bit |
| freeze_req_i | input | 1 | Freeze request register bit |
| auto_wake_en_i | input | 1 | Wake on bus activity enable |
| auto_bo_exit_en_i | input | 1 | Automatic bus-off recovery enable |
| busy_i | input | 1 | Engine transmitting or receiving a frame |
| bus_off_i | input | 1 | Engine error state is bus-off |
| sof_det_i | input | 1 | Bus activity / start of frame seen |
| sample_i | input | 1 | Sample-point strobe |
| rx_i | input | 1 | Sampled RX level (1 = recessive) |
| tx_eng_i | input | 1 | Transmit bit from the engine |
| mode_o | output | 2 | Current mode code |
| sleep_ack_o | output | 1 | Sleep acknowledge |
| freeze_ack_o | output | 1 | Freeze acknowledge |
| engine_run_o | output | 1 | Release of the protocol engine |
| tx_o | output | 1 | Gated transmit line |
| idle_pulse_o | output | 1 | Bus-idle detected pulse |
| sleep_clr_o | output | 1 | Pulse to clear the sleep request bit |
| bo_recover_o | output | 1 | Pulse to the engine to reset after bus-off |

## Verification
The assertions assume that the engine raises `bus_off_i` only while running, and that `busy_i` describes the engine's own frame activity. They also assume that the sample strobe is a single-cycle event, so one sample can never count twice. The stimulus keeps to these assumptions. Sample strobes are issued once every four cycles. `bus_off_i` is pulsed only in normal mode and then dropped. Software behaviour is mimicked by clearing the sleep request after the clear strobe. Request changes are made between frames, apart from the deliberate busy cases that test deferred entry.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP, ST_WAKE, ST_FRZ, ST_FRZ_EXIT, ST_RUN, ST_BOFF
  } seq_state_e;

  localparam logic [1:0] MODE_SLEEP  = 2'b00;
  localparam logic [1:0] MODE_FREEZE = 2'b01;
  localparam logic [1:0] MODE_NORMAL = 2'b10;
  localparam logic [1:0] MODE_BUSOFF = 2'b11;
endpackage

// File: rtl/can_idle_det.sv
module can_idle_det #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic sample_i,
  input  logic rx_i,
  output logic idle_o
);
  localparam int CNT_W = $clog2(IDLE_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (!arm_i) begin
      cnt_q  <= '0;
      idle_q <= 1'b0;
    end else if (sample_i) begin
      if (!rx_i) begin
        cnt_q  <= '0;
        idle_q <= 1'b0;
      end else if (cnt_q == LAST) begin
        cnt_q  <= '0;
        idle_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        idle_q <= 1'b0;
      end
    end else begin
      idle_q <= 1'b0;
    end
  end

  assign idle_o = idle_q;
endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       freeze_req_i,
  input  logic       auto_wake_en_i,
  input  logic       auto_bo_exit_en_i,
  input  logic       busy_i,
  input  logic       bus_off_i,
  input  logic       sof_det_i,
  input  logic       idle_i,
  output seq_state_e state_o,
  output logic       idle_arm_o,
  output logic       sleep_clr_o,
  output logic       bo_recover_o
);
  seq_state_e state_q, state_d;
  logic bo_pend_q, bo_pend_d;
  logic clr_q, clr_d;
  logic rec_q, rec_d;

  always_comb begin
    state_d   = state_q;
    bo_pend_d = bo_pend_q;
    clr_d     = 1'b0;
    rec_d     = 1'b0;
    unique case (state_q)
      ST_SLEEP: begin
        if (freeze_req_i)      state_d = ST_FRZ;
        else if (!sleep_req_i) state_d = ST_WAKE;
        else if (auto_wake_en_i && sof_det_i) begin
          state_d = ST_WAKE;
          clr_d   = 1'b1;
        end
      end
      ST_WAKE: begin
        if (freeze_req_i) state_d = ST_FRZ;
        else if (idle_i)  state_d = ST_RUN;
      end
      ST_RUN: begin
        if (bus_off_i)                      state_d = ST_BOFF;
        else if (!busy_i && freeze_req_i)   state_d = ST_FRZ;
        else if (!busy_i && sleep_req_i)    state_d = ST_SLEEP;
      end
      ST_FRZ: begin
        if (!freeze_req_i) state_d = ST_FRZ_EXIT;
      end
      ST_FRZ_EXIT: begin
        if (freeze_req_i) state_d = ST_FRZ;
        else if (idle_i) begin
          state_d   = ST_RUN;
          rec_d     = bo_pend_q;
          bo_pend_d = 1'b0;
        end
      end
      ST_BOFF: begin
        if (freeze_req_i) begin
          state_d   = ST_FRZ;
          bo_pend_d = 1'b1;
        end else if (auto_bo_exit_en_i && idle_i) begin
          state_d = ST_RUN;
          rec_d   = 1'b1;
        end
      end
      default: state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SLEEP;
      bo_pend_q <= 1'b0;
      clr_q     <= 1'b0;
      rec_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      bo_pend_q <= bo_pend_d;
      clr_q     <= clr_d;
      rec_q     <= rec_d;
    end
  end

  assign state_o      = state_q;
  assign idle_arm_o   = (state_q == ST_WAKE) || (state_q == ST_FRZ_EXIT) || (state_q == ST_BOFF);
  assign sleep_clr_o  = clr_q;
  assign bo_recover_o = rec_q;
endmodule

// File: rtl/can_mode_out.sv
module can_mode_out
  import can_mode_pkg::*;
(
  input  seq_state_e state_i,
  input  logic       tx_eng_i,
  output logic [1:0] mode_o,
  output logic       sleep_ack_o,
  output logic       freeze_ack_o,
  output logic       engine_run_o,
  output logic       tx_o
);
  always_comb begin
    unique case (state_i)
      ST_SLEEP, ST_WAKE:   mode_o = MODE_SLEEP;
      ST_FRZ, ST_FRZ_EXIT: mode_o = MODE_FREEZE;
      ST_RUN:              mode_o = MODE_NORMAL;
      default:             mode_o = MODE_BUSOFF;
    endcase
  end

  assign sleep_ack_o  = (mode_o == MODE_SLEEP);
  assign freeze_ack_o = (mode_o == MODE_FREEZE);
  assign engine_run_o = (mode_o == MODE_NORMAL);
  // held engine never drives a dominant bit
  assign tx_o         = engine_run_o ? tx_eng_i : 1'b1;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  input  logic       freeze_req_i,
  input  logic       auto_wake_en_i,
  input  logic       auto_bo_exit_en_i,
  input  logic       busy_i,
  input  logic       bus_off_i,
  input  logic       sof_det_i,
  input  logic       sample_i,
  input  logic       rx_i,
  input  logic       tx_eng_i,
  output logic [1:0] mode_o,
  output logic       sleep_ack_o,
  output logic       freeze_ack_o,
  output logic       engine_run_o,
  output logic       tx_o,
  output logic       idle_pulse_o,
  output logic       sleep_clr_o,
  output logic       bo_recover_o
);
  seq_state_e state;
  logic       idle_arm;
  logic       idle;

  can_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (idle_arm),
    .sample_i(sample_i),
    .rx_i    (rx_i),
    .idle_o  (idle)
  );

  can_mode_fsm u_fsm (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .sleep_req_i      (sleep_req_i),
    .freeze_req_i     (freeze_req_i),
    .auto_wake_en_i   (auto_wake_en_i),
    .auto_bo_exit_en_i(auto_bo_exit_en_i),
    .busy_i           (busy_i),
    .bus_off_i        (bus_off_i),
    .sof_det_i        (sof_det_i),
    .idle_i           (idle),
    .state_o          (state),
    .idle_arm_o       (idle_arm),
    .sleep_clr_o      (sleep_clr_o),
    .bo_recover_o     (bo_recover_o)
  );

  can_mode_out u_out (
    .state_i     (state),
    .tx_eng_i    (tx_eng_i),
    .mode_o      (mode_o),
    .sleep_ack_o (sleep_ack_o),
    .freeze_ack_o(freeze_ack_o),
    .engine_run_o(engine_run_o),
    .tx_o        (tx_o)
  );

  assign idle_pulse_o = idle;
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk
  import can_mode_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       auto_wake_en_i,
  input logic       auto_bo_exit_en_i,
  input logic       busy_i,
  input logic       bus_off_i,
  input logic       sof_det_i,
  input logic       sample_i,
  input logic       rx_i,
  input logic       tx_eng_i,
  input logic [1:0] mode_o,
  input logic       sleep_ack_o,
  input logic       freeze_ack_o,
  input logic       engine_run_o,
  input logic       tx_o,
  input logic       idle_pulse_o,
  input logic       sleep_clr_o,
  input logic       bo_recover_o
);
  a_r2_sleep_exit_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_ack_o && !idle_pulse_o) |=> !engine_run_o);

  a_r3_clr_from_activity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_clr_o |-> $past(sof_det_i && auto_wake_en_i));

  // R11 is covered by the same property: no sleep entry while busy
  a_r4_no_entry_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_NORMAL && busy_i) |=> (mode_o == MODE_NORMAL || mode_o == MODE_BUSOFF));

  a_r5_freeze_exit_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_ack_o && !idle_pulse_o) |=> !engine_run_o);

  a_r6_idle_after_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_pulse_o |-> $past(sample_i && rx_i));

  a_r6_idle_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_pulse_o |=> !idle_pulse_o);

  a_r7_acks_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sleep_ack_o && freeze_ack_o));

  a_r8_busoff_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_NORMAL && bus_off_i) |=> mode_o == MODE_BUSOFF);

  a_r8_recover_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bo_recover_o |=> !bo_recover_o);

  a_r9_busoff_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_BUSOFF && !auto_bo_exit_en_i) |=> mode_o != MODE_NORMAL);

  a_r10_tx_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !engine_run_o |-> tx_o);

  a_r10_tx_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engine_run_o |-> (tx_o == tx_eng_i));
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .auto_wake_en_i   (auto_wake_en_i),
  .auto_bo_exit_en_i(auto_bo_exit_en_i),
  .busy_i           (busy_i),
  .bus_off_i        (bus_off_i),
  .sof_det_i        (sof_det_i),
  .sample_i         (sample_i),
  .rx_i             (rx_i),
  .tx_eng_i         (tx_eng_i),
  .mode_o           (mode_o),
  .sleep_ack_o      (sleep_ack_o),
  .freeze_ack_o     (freeze_ack_o),
  .engine_run_o     (engine_run_o),
  .tx_o             (tx_o),
  .idle_pulse_o     (idle_pulse_o),
  .sleep_clr_o      (sleep_clr_o),
  .bo_recover_o     (bo_recover_o)
);

// File: tb/can_mode_seq_tb_top.sv
module can_mode_seq_tb_top;
  localparam int IDLE_N = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b1, freeze_req = 1'b0, auto_wake = 1'b0, auto_bo = 1'b0;
  logic busy = 1'b0, bus_off = 1'b0, sof = 1'b0, sample = 1'b0, rx = 1'b1, tx_eng = 1'b0;
  logic [1:0] mode;
  logic sleep_ack, freeze_ack, run, tx, idle_p, clr, rec;

  always #10 clk = ~clk;

  can_mode_seq #(.IDLE_BITS(IDLE_N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .freeze_req_i(freeze_req),
    .auto_wake_en_i(auto_wake), .auto_bo_exit_en_i(auto_bo), .busy_i(busy),
    .bus_off_i(bus_off), .sof_det_i(sof), .sample_i(sample), .rx_i(rx), .tx_eng_i(tx_eng),
    .mode_o(mode), .sleep_ack_o(sleep_ack), .freeze_ack_o(freeze_ack),
    .engine_run_o(run), .tx_o(tx), .idle_pulse_o(idle_p), .sleep_clr_o(clr),
    .bo_recover_o(rec)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit clr_seen = 0, rec_seen = 0;
  int both_ack = 0;
  bit done = 0;

  // behavioural reference: 0 asleep, 1 waking, 2 frozen, 3 leaving freeze, 4 normal, 5 bus-off
  int m_st = 0, m_cnt = 0;
  bit m_idle = 0, m_clr = 0, m_rec = 0, m_pend = 0;
  int mode_of[6] = '{0, 0, 1, 1, 2, 3};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_idle = 0; m_clr = 0; m_rec = 0; m_pend = 0;
    end else begin
      int nst;
      bit nclr, nrec, nidle;
      nst = m_st; nclr = 0; nrec = 0;
      case (m_st)
        0: if (freeze_req) nst = 2; else if (!sleep_req) nst = 1;
           else if (auto_wake && sof) begin nst = 1; nclr = 1; end
        1: if (freeze_req) nst = 2; else if (m_idle) nst = 4;
        2: if (!freeze_req) nst = 3;
        3: if (freeze_req) nst = 2; else if (m_idle) begin nst = 4; nrec = m_pend; m_pend = 0; end
        4: if (bus_off) nst = 5; else if (!busy && freeze_req) nst = 2;
           else if (!busy && sleep_req) nst = 0;
        default: if (freeze_req) begin nst = 2; m_pend = 1; end
                 else if (auto_bo && m_idle) begin nst = 4; nrec = 1; end
      endcase
      nidle = 0;
      if (!(m_st == 1 || m_st == 3 || m_st == 5)) m_cnt = 0;
      else if (sample) begin
        if (!rx) m_cnt = 0;
        else if (m_cnt == IDLE_N - 1) begin m_cnt = 0; nidle = 1; end
        else m_cnt++;
      end
      m_st = nst; m_clr = nclr; m_rec = nrec; m_idle = nidle;
    end
  end

  bit prev_idle = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int em;
      bit etx;
      em  = mode_of[m_st];
      etx = (m_st == 4) ? tx_eng : 1'b1;
      n_chk++;
      if (mode !== 2'(em) || sleep_ack !== (em == 0) || freeze_ack !== (em == 1) ||
          run !== (em == 2) || tx !== etx || idle_p !== m_idle || clr !== m_clr || rec !== m_rec) begin
        n_fail++;
        $display("FAIL %s: cycle compare mode/sack/fack/run/tx/idle/clr/rec act=%0d%0b%0b%0b%0b%0b%0b%0b exp=%0d%0b%0b%0b%0b%0b%0b%0b",
                 cur_req, mode, sleep_ack, freeze_ack, run, tx, idle_p, clr, rec,
                 em, em == 0, em == 1, em == 2, etx, m_idle, m_clr, m_rec);
      end
      if (clr) clr_seen = 1;
      if (rec) rec_seen = 1;
      if (sleep_ack && freeze_ack) both_ack++;
      if (idle_p && prev_idle) begin
        n_fail++;
        $display("FAIL R6: idle pulse width act=2+ exp=1");
      end
      prev_idle = idle_p;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic bit_(input logic v);
    rx = v; sample = 1'b1; step();
    sample = 1'b0; step(); step(); step();
  endtask

  task automatic bits(input int n, input logic v);
    for (int i = 0; i < n; i++) bit_(v);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    rst_n = 1'b1;
    step();
    cur_req = "R1";
    chk("R1", "mode", mode, 0);
    chk("R1", "sleep_ack", sleep_ack, 1);
    chk("R1", "freeze_ack", freeze_ack, 0);
    chk("R1", "engine_run", run, 0);
    chk("R1", "tx", tx, 1);

    cur_req = "R2";
    sof = 1'b1; step(); sof = 1'b0; step(); step(); step();
    chk("R2", "mode after ignored activity", mode, 0);
    chk("R2", "clear strobe", clr_seen, 0);
    sleep_req = 1'b0; step();
    chk("R2", "sleep_ack while waiting idle", sleep_ack, 1);
    bits(5, 1'b1);
    chk("R2", "mode before idle", mode, 0);
    bits(7, 1'b1);
    chk("R2", "mode after idle", mode, 2);
    chk("R2", "engine_run", run, 1);

    cur_req = "R10";
    tx_eng = 1'b0; step();
    chk("R10", "tx follows engine", tx, 0);
    tx_eng = 1'b1; step();
    chk("R10", "tx follows engine high", tx, 1);

    cur_req = "R11";
    busy = 1'b1; sleep_req = 1'b1; step(); step(); step(); step();
    chk("R11", "mode while busy", mode, 2);
    busy = 1'b0; step();
    chk("R11", "mode after frame", mode, 0);
    tx_eng = 1'b0; step();
    chk("R10", "tx held in sleep", tx, 1);

    cur_req = "R3";
    auto_wake = 1'b1; sof = 1'b1; step(); sof = 1'b0;
    chk("R3", "clear strobe", clr_seen, 1);
    chk("R3", "sleep_ack during wake", sleep_ack, 1);
    sleep_req = 1'b0;
    bits(12, 1'b1);
    chk("R3", "mode after idle", mode, 2);

    cur_req = "R4";
    busy = 1'b1; freeze_req = 1'b1; step(); step(); step(); step(); step();
    chk("R4", "mode while busy", mode, 2);
    busy = 1'b0; step();
    chk("R4", "mode after frame", mode, 1);
    chk("R4", "freeze_ack", freeze_ack, 1);
    chk("R4", "sleep_ack", sleep_ack, 0);

    cur_req = "R5";
    freeze_req = 1'b0; step();
    bits(8, 1'b1); bits(1, 1'b0); bits(10, 1'b1);
    chk("R5", "mode after 10 recessive", mode, 1);
    cur_req = "R6";
    bits(1, 1'b1);
    chk("R5", "mode after 11 recessive", mode, 2);

    cur_req = "R7";
    sleep_req = 1'b1; step();
    chk("R7", "mode sleep", mode, 0);
    freeze_req = 1'b1; step();
    chk("R7", "freeze_ack from sleep", freeze_ack, 1);
    chk("R7", "sleep_ack from sleep", sleep_ack, 0);
    freeze_req = 1'b0; sleep_req = 1'b0;
    bits(12, 1'b1);
    chk("R7", "mode normal", mode, 2);
    sleep_req = 1'b1; freeze_req = 1'b1; step();
    chk("R7", "priority", mode, 1);
    freeze_req = 1'b0; sleep_req = 1'b0;
    bits(12, 1'b1);
    chk("R7", "mode normal again", mode, 2);

    cur_req = "R8";
    auto_bo = 1'b1; bus_off = 1'b1; step(); bus_off = 1'b0;
    chk("R8", "mode bus-off", mode, 3);
    chk("R10", "tx held in bus-off", tx, 1);
    rec_seen = 0;
    bits(12, 1'b1);
    chk("R8", "mode after recovery", mode, 2);
    chk("R8", "recover pulse", rec_seen, 1);

    cur_req = "R9";
    auto_bo = 1'b0; bus_off = 1'b1; step(); bus_off = 1'b0;
    rec_seen = 0;
    bits(30, 1'b1);
    chk("R9", "mode held in bus-off", mode, 3);
    chk("R9", "no recover pulse", rec_seen, 0);
    freeze_req = 1'b1; step();
    chk("R9", "mode freeze", mode, 1);
    freeze_req = 1'b0;
    bits(12, 1'b1);
    chk("R9", "mode after freeze cycle", mode, 2);
    chk("R9", "recover pulse", rec_seen, 1);

    chk("R7", "cycles with both acks", both_ack, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule